// File: doc/BRIEF.md
# Either-Edge GPIO Interrupt Controller

This block watches a small set of general-purpose input pins and records a flag for a pin whenever its level changes, rising or falling alike. The pins are brought into the clock domain through a two-stage synchroniser. An edge is found by comparing each synchronised level with the sample taken one clock earlier. The flags sit in one status register together with a flag for a main-rail power-on reset. Software reads this register over a simple register bus and clears flags by writing ones to them.

The interrupt output is a registered level. It is the OR, over all pins, of this condition: the pin's flag is set, its per-pin enable is on, the either-edge function is selected for it, and the combined enable of its pin group is on. Flags are recorded even when none of these controls is set. The direction and polarity settings have no effect on edge capture. Polarity does invert the pin level read back in the data register. A main-rail power-on reset event sets the power flag. When that reset is also the cause of the system turning on, the block emits a one-cycle system control interrupt pulse.

Top module: `dual_edge_irq_ctrl`

## Requirements
- R1: A pin level change that is first sampled at clock edge n sets that pin's status flag at edge n+2. Status register (address 0) bit i belongs to pin i.
- R2: Both a low-to-high and a high-to-low change of a pin set its flag.
- R3: In the status register, bit 4 is the power flag and bits 7..5 always read 0. Unmapped address 7 reads 0.
- R4: A write to address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: When an edge and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: Flags are recorded whatever the per-pin enables, function selects and group enables hold.
- R7: irq_o goes high one cycle after some pin i has flag, per-pin enable (address 1 bit i), function select (address 2 bit i) and group enable all set. Pins 0 and 1 use address 3 bit 0, and pins 2 and 3 use address 3 bit 1. irq_o stays high until such a flag is cleared.
- R8: Polarity (address 4) and direction (address 6) do not change edge capture. Address 5 reads the synchronised pin levels XOR polarity, and address 6 reads back the direction bits.
- R9: por_evt_i sets status bit 4 at the same edge. sci_o is high for exactly the cycle after a clock in which por_evt_i and boot_by_por_i are both high.
- R10: Synchronous active-high rst clears all registers, flags and outputs to 0.
- R11: bus_rdata_o holds the register that bus_addr_i selected at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (battery-domain power-on) |
| pin_i | input | 4 | Asynchronous monitored pin levels |
| por_evt_i | input | 1 | One-cycle main-rail power-on reset event |
| boot_by_por_i | input | 1 | System turned on because of that reset |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined either-edge interrupt level |
| sci_o | output | 1 | One-cycle system control interrupt pulse |

## Verification
The pins are driven with single rising edges, single falling edges and changes on two pins at once. This separates a detector that sees both edge directions from one that sees only one. The enables are opened one layer at a time, and each group is lit from a pin of its own. This shows whether the per-pin enable, the function select and the correct group enable are each part of the interrupt condition. A clear is written in the exact cycle of a new edge to show which of the two wins. Polarity and direction are set before an edge, which shows that they act only on the data readback. A behavioural model checks the interrupt, the pulse and the read data on every clock.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] reg_addr_t;
  localparam reg_addr_t ADR_STAT = 3'd0;
  localparam reg_addr_t ADR_PEN  = 3'd1;
  localparam reg_addr_t ADR_FSEL = 3'd2;
  localparam reg_addr_t ADR_GEN  = 3'd3;
  localparam reg_addr_t ADR_POL  = 3'd4;
  localparam reg_addr_t ADR_DATA = 3'd5;
  localparam reg_addr_t ADR_DIR  = 3'd6;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r1, r2;
    always_ff @(posedge clk) begin
      if (rst) begin
        r1 <= 1'b0;
        r2 <= 1'b0;
      end else begin
        r1 <= d_i[i];
        r2 <= r1;
      end
    end
    assign q_o[i] = r2;
  end
endmodule

// File: rtl/eirq_edge_stat.sv
module eirq_edge_stat #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  input  logic [N:0]   clr_i,
  input  logic         por_i,
  output logic [N-1:0] edge_o,
  output logic [N:0]   stat_o
);
  logic [N-1:0] prev_q;
  logic [N:0]   stat_q;

  // a change in either direction counts as an event
  assign edge_o = lvl_i ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // set terms are OR-ed after the clear so a new event is never lost
      stat_q <= (stat_q & ~clr_i) | {por_i, edge_o};
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/eirq_cfg_regs.sv
module eirq_cfg_regs
  import eirq_pkg::*;
#(
  parameter int N      = 4,
  parameter int G      = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  reg_addr_t         addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N:0]        stat_i,
  input  logic [N-1:0]      lvl_i,
  output logic [N:0]        clr_o,
  output logic [N-1:0]      pen_o,
  output logic [N-1:0]      fsel_o,
  output logic [G-1:0]      gen_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0]      pen_q, fsel_q, pol_q, dir_q;
  logic [G-1:0]      gen_q;
  logic [DATA_W-1:0] rdata_q, rd_next;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:N+1];

  assign clr_o = (wr_i && addr_i == ADR_STAT) ? wdata_i[N:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pen_q  <= '0;
      fsel_q <= '0;
      gen_q  <= '0;
      pol_q  <= '0;
      dir_q  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        ADR_PEN:  pen_q  <= wdata_i[N-1:0];
        ADR_FSEL: fsel_q <= wdata_i[N-1:0];
        ADR_GEN:  gen_q  <= wdata_i[G-1:0];
        ADR_POL:  pol_q  <= wdata_i[N-1:0];
        ADR_DIR:  dir_q  <= wdata_i[N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      ADR_STAT: rd_next[N:0]   = stat_i;
      ADR_PEN:  rd_next[N-1:0] = pen_q;
      ADR_FSEL: rd_next[N-1:0] = fsel_q;
      ADR_GEN:  rd_next[G-1:0] = gen_q;
      ADR_POL:  rd_next[N-1:0] = pol_q;
      ADR_DATA: rd_next[N-1:0] = lvl_i ^ pol_q;
      ADR_DIR:  rd_next[N-1:0] = dir_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign pen_o   = pen_q;
  assign fsel_o  = fsel_q;
  assign gen_o   = gen_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/dual_edge_irq_ctrl.sv
module dual_edge_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int NUM_PINS   = 4,
  parameter int NUM_GROUPS = 2,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic              por_evt_i,
  input  logic              boot_by_por_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sci_o
);
  localparam int PINS_PER_GRP = NUM_PINS / NUM_GROUPS;

  logic [NUM_PINS-1:0]   sync_q, edge_vec, pen, fsel, pin_irq;
  logic [NUM_PINS:0]     stat_q, clr_vec;
  logic [NUM_GROUPS-1:0] gen;
  logic                  irq_q, sci_q;

  eirq_sync #(.W(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (sync_q)
  );

  eirq_edge_stat #(.N(NUM_PINS)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (sync_q),
    .clr_i  (clr_vec),
    .por_i  (por_evt_i),
    .edge_o (edge_vec),
    .stat_o (stat_q)
  );

  eirq_cfg_regs #(.N(NUM_PINS), .G(NUM_GROUPS), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .wdata_i (bus_wdata_i),
    .stat_i  (stat_q),
    .lvl_i   (sync_q),
    .clr_o   (clr_vec),
    .pen_o   (pen),
    .fsel_o  (fsel),
    .gen_o   (gen),
    .rdata_o (bus_rdata_o)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pin_irq[i] = stat_q[i] & pen[i] & fsel[i] & gen[i / PINS_PER_GRP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      sci_q <= 1'b0;
    end else begin
      irq_q <= |pin_irq;
      sci_q <= por_evt_i & boot_by_por_i;
    end
  end

  assign irq_o = irq_q;
  assign sci_o = sci_q;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk
  import eirq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                por_evt_i,
  input logic                boot_by_por_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic                bus_wr_i,
  input logic [DATA_W-1:0]   bus_wdata_i,
  input logic [DATA_W-1:0]   bus_rdata_o,
  input logic                irq_o,
  input logic                sci_o,
  input logic [NUM_PINS-1:0] edge_vec,
  input logic [NUM_PINS:0]   stat_q
);
  // R1 R5
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|edge_vec) |=> ((stat_q[NUM_PINS-1:0] & $past(edge_vec)) == $past(edge_vec)));

  // R4
  zero_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == ADR_STAT) |=>
      ((stat_q & $past(stat_q) & ~$past(bus_wdata_i[NUM_PINS:0]))
        == ($past(stat_q) & ~$past(bus_wdata_i[NUM_PINS:0]))));

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr_i) == ADR_STAT) |-> (bus_rdata_o[DATA_W-1:NUM_PINS+1] == '0));

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|stat_q[NUM_PINS-1:0]));

  // R9
  sci_cause_chk: assert property (@(posedge clk) disable iff (rst)
    sci_o |-> $past(por_evt_i && boot_by_por_i));

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !sci_o && bus_rdata_o == '0));
endmodule

bind dual_edge_irq_ctrl eirq_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .por_evt_i     (por_evt_i),
  .boot_by_por_i (boot_by_por_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wr_i      (bus_wr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .irq_o         (irq_o),
  .sci_o         (sci_o),
  .edge_vec      (edge_vec),
  .stat_q        (stat_q)
);

// File: tb/sim_dual_edge_irq_ctrl.sv
module sim_dual_edge_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pins = 4'h0;
  logic       por = 1'b0, boot = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sci;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_edge_irq_ctrl u0 (
    .clk(clk), .rst(rst), .pin_i(pins), .por_evt_i(por), .boot_by_por_i(boot),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .sci_o(sci)
  );

  // behavioural reference model
  logic [3:0] hist[$] = '{4'h0, 4'h0, 4'h0};
  logic [4:0] m_stat = '0;
  logic [3:0] m_en = '0, m_sel = '0, m_pol = '0, m_dir = '0;
  logic [1:0] m_grp = '0;
  logic       m_irq = 1'b0, m_sci = 1'b0;
  logic [7:0] m_rd = '0;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{4'h0, 4'h0, 4'h0};
      m_stat = '0; m_en = '0; m_sel = '0; m_pol = '0; m_dir = '0; m_grp = '0;
      m_irq = 1'b0; m_sci = 1'b0; m_rd = '0;
    end else begin
      logic [3:0] ev;
      logic [4:0] clr;
      ev = hist[1] ^ hist[2];
      case (addr)
        3'd0: m_rd = {3'b000, m_stat};
        3'd1: m_rd = {4'h0, m_en};
        3'd2: m_rd = {4'h0, m_sel};
        3'd3: m_rd = {6'h00, m_grp};
        3'd4: m_rd = {4'h0, m_pol};
        3'd5: m_rd = {4'h0, hist[1] ^ m_pol};
        3'd6: m_rd = {4'h0, m_dir};
        default: m_rd = 8'h00;
      endcase
      m_irq = |(m_stat[3:0] & m_en & m_sel & {m_grp[1], m_grp[1], m_grp[0], m_grp[0]});
      m_sci = por & boot;
      clr = (wr && addr == 3'd0) ? wdata[4:0] : 5'h00;
      m_stat = (m_stat & ~clr) | {por, ev};
      if (wr) begin
        case (addr)
          3'd1: m_en  = wdata[3:0];
          3'd2: m_sel = wdata[3:0];
          3'd3: m_grp = wdata[1:0];
          3'd4: m_pol = wdata[3:0];
          3'd6: m_dir = wdata[3:0];
          default: ;
        endcase
      end
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(irq == m_irq, "R7 irq vs model", irq, m_irq);
      check(sci == m_sci, "R9 sci vs model", sci, m_sci);
      check(rdata == m_rd, "R11 rdata vs model", rdata, m_rd);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd_reg(a, v);
    check(v == e, tag, v, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    check(irq == 1'b0 && sci == 1'b0, "R10 outputs after reset", {irq, sci}, 0);
    expect_reg(3'd0, 8'h00, "R10 status after reset");

    // R1 exact latency: change sampled at edge n, flag at n+2
    pins = 4'h1; addr = 3'd0;
    tick(3);
    check(rdata == 8'h00, "R1 flag not yet visible", rdata, 8'h00);
    tick(1);
    check(rdata == 8'h01, "R1 rising edge flag", rdata, 8'h01);

    wr_reg(3'd0, 8'h01);
    expect_reg(3'd0, 8'h00, "R4 write-one clears");
    pins = 4'h0; tick(5);
    expect_reg(3'd0, 8'h01, "R2 falling edge flag");
    wr_reg(3'd0, 8'h00);
    expect_reg(3'd0, 8'h01, "R4 write-zero keeps");
    wr_reg(3'd0, 8'hFF);
    expect_reg(3'd0, 8'h00, "R4 clear all");

    // R6 flag with nothing enabled
    pins = 4'h8; tick(5);
    expect_reg(3'd0, 8'h08, "R6 flag without enables");
    check(irq == 1'b0, "R6 no irq without enables", irq, 0);

    // R7 enable layering and groups
    wr_reg(3'd1, 8'h0F); wr_reg(3'd2, 8'h0F); wr_reg(3'd3, 8'h01); tick(2);
    check(irq == 1'b0, "R7 wrong group enabled", irq, 0);
    wr_reg(3'd3, 8'h02); tick(2);
    check(irq == 1'b1, "R7 group 2 enabled", irq, 1);
    wr_reg(3'd2, 8'h07); tick(2);
    check(irq == 1'b0, "R7 select off", irq, 0);
    wr_reg(3'd2, 8'h0F); wr_reg(3'd1, 8'h07); tick(2);
    check(irq == 1'b0, "R7 pin enable off", irq, 0);
    wr_reg(3'd1, 8'h0F); tick(2);
    check(irq == 1'b1, "R7 level held", irq, 1);
    wr_reg(3'd0, 8'h08); tick(2);
    check(irq == 1'b0, "R7 drops after clear", irq, 0);
    pins = 4'h9; tick(5);
    wr_reg(3'd3, 8'h01); tick(2);
    check(irq == 1'b1, "R7 group 1 enabled", irq, 1);
    wr_reg(3'd0, 8'hFF); tick(2);
    check(irq == 1'b0, "R7 cleared", irq, 0);
    wr_reg(3'd3, 8'h00);

    // R8 polarity and direction
    wr_reg(3'd4, 8'h0F); wr_reg(3'd6, 8'h0F);
    expect_reg(3'd5, 8'h06, "R8 data readback inverted");
    pins = 4'hB; tick(5);
    expect_reg(3'd0, 8'h02, "R8 edge despite polarity and direction");
    expect_reg(3'd5, 8'h04, "R8 data after change");
    expect_reg(3'd6, 8'h0F, "R8 direction readback");
    wr_reg(3'd0, 8'hFF);

    // R5 set beats clear in the same cycle
    pins = 4'hF;
    tick(2);
    wr_reg(3'd0, 8'h04);
    expect_reg(3'd0, 8'h04, "R5 set wins over clear");

    // R9 power flag and pulse
    por = 1'b1; boot = 1'b1;
    tick(1);
    por = 1'b0;
    check(sci == 1'b1, "R9 pulse high", sci, 1);
    tick(1);
    check(sci == 1'b0, "R9 pulse one cycle", sci, 0);
    expect_reg(3'd0, 8'h14, "R9 power flag set");
    wr_reg(3'd0, 8'hFF);
    por = 1'b1; boot = 1'b0;
    tick(1);
    por = 1'b0;
    check(sci == 1'b0, "R9 no pulse without boot cause", sci, 0);
    expect_reg(3'd0, 8'h10, "R9 flag set without boot cause");
    wr_reg(3'd0, 8'hFF);
    expect_reg(3'd0, 8'h00, "R3 reserved bits zero");
    expect_reg(3'd7, 8'h00, "R3 unmapped address");
    tick(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule